// File: doc/BRIEF.md
# Phase-Frequency Detector with Digital Lock Filter

This block sits at the comparison point of an integer-N synthesizer loop. A reference edge stream enters a programmable divider that passes one edge for every R+1 it receives. The feedback stream from the divided VCO is compared with that divided reference by a three-state phase-frequency detector. The detector has two active-low outputs. The up output goes low when the reference edge leads. The down output goes low when the feedback edge leads. Each pulse lasts as many clock cycles as the two edges are apart.

Every part of the block runs on one fast sampling clock, and both inputs are sampled signals. A lock flag takes the place of an external RC filter on the NAND of the two detector outputs. It counts comparison periods whose pulse stays within a cycle limit. It asserts after a run of such periods and drops at once when a pulse runs too long.

Top module: `pfd_lock_top`

## Requirements
- R1: With `div_ratio` = R, `ref_div` produces one single-cycle pulse for every R+1 rising edges of `ref_in`. The pulse comes one clock after the sampling edge that sees the completing reference edge. The count restarts after each pulse.
- R2: With `div_ratio` = 0, every rising edge of `ref_in` appears on `ref_div`.
- R3: When the divided reference edge leads the feedback edge by d cycles, `up_n` is low for exactly d cycles and `dn_n` stays high.
- R4: When the feedback edge leads the divided reference edge by d cycles, `dn_n` is low for exactly d cycles and `up_n` stays high.
- R5: When both edges are sampled in the same cycle, neither output goes low.
- R6: Only rising edges act. A `fb_in` level that stays high for several cycles counts as one edge.
- R7: Once both edges have been seen, both outputs return high on the same clock. `up_n` and `dn_n` are never low together.
- R8: `lock` goes high after 16 consecutive completed comparisons (parameter `LOCK_PERIODS`) in which the active pulse lasts no more than `MAX_PULSE` cycles (default 4). A comparison with no pulse counts as good.
- R9: A pulse that reaches `MAX_PULSE`+1 cycles clears `lock` on the clock that ends that cycle. It also restarts the count of good comparisons.
- R10: Reset, while asserted, holds `up_n` and `dn_n` high and `lock` and `ref_div` low. Reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| div_ratio | input | 6 | Reference divide value R; the divide factor is R+1 |
| ref_in | input | 1 | Sampled reference stream |
| fb_in | input | 1 | Sampled divided-VCO feedback stream |
| ref_div | output | 1 | Divided reference pulse |
| up_n | output | 1 | Active-low pump-up pulse |
| dn_n | output | 1 | Active-low pump-down pulse |
| lock | output | 1 | Filtered lock indication |

## Verification
The bench measures pulse widths at both leads and signs of offset. A detector whose two input paths had different latency would show a stray one-cycle pulse for edges that arrive together, and a width that is off by one elsewhere. It holds the feedback level high across several samples. A level-sensitive detector would then pulse again or stretch the down pulse. It places pulses at exactly `MAX_PULSE` and at one cycle more, tracking the good-period streak, so a filter that is off by one on the limit or on the period count shows the wrong `lock`. An asynchronous reset issued while the up output is pending shows whether the pending state really clears.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;

  // Pending-edge state of the three-state detector (active high internally)
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  localparam pfd_state_t PFD_IDLE = '{up: 1'b0, dn: 1'b0};

endpackage

// File: rtl/pfdl_ref_divider.sv
module pfdl_ref_divider #(
  parameter int unsigned RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  input  logic          ref_in,
  output logic          div_pulse
);

  localparam logic [RW-1:0] CNT_ONE = RW'(1);

  logic          ref_q;
  logic          ref_rise;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          div_d, div_q;

  // Next state: count reference rising edges, fire when the count reaches ratio
  always_comb begin
    ref_rise = ref_in & ~ref_q;
    cnt_d    = cnt_q;
    div_d    = 1'b0;
    if (ref_rise) begin
      if (cnt_q >= ratio) begin
        cnt_d = '0;
        div_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_pulse = div_q;

endmodule

// File: rtl/pfdl_pfd_core.sv
module pfdl_pfd_core
  import pfdl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,    // one-cycle event, already one register behind its edge
  input  logic fb_in,
  output logic up_n,
  output logic dn_n,
  output logic cmp_done   // cycle in which the later of the two edges resolves
);

  logic       fb_q;
  logic       fb_rise;
  logic       fb_ev_q;    // balances the register stage of the reference path
  pfd_state_t st_q, st_d;

  always_comb begin
    fb_rise  = fb_in & ~fb_q;
    st_d.up  = st_q.up | ref_ev;
    st_d.dn  = st_q.dn | fb_ev_q;
    cmp_done = 1'b0;
    if (st_d.up && st_d.dn) begin
      st_d     = PFD_IDLE;
      cmp_done = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q    <= 1'b0;
      fb_ev_q <= 1'b0;
      st_q    <= PFD_IDLE;
    end else begin
      fb_q    <= fb_in;
      fb_ev_q <= fb_rise;
      st_q    <= st_d;
    end
  end

  assign up_n = ~st_q.up;
  assign dn_n = ~st_q.dn;

endmodule

// File: rtl/pfdl_lock_filter.sv
module pfdl_lock_filter #(
  parameter int unsigned MAX_PULSE    = 4,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_n,
  input  logic dn_n,
  input  logic cmp_done,
  output logic lock
);

  localparam int unsigned RUNW = $clog2(MAX_PULSE + 2);
  localparam int unsigned CNTW = $clog2(LOCK_PERIODS + 1);
  localparam logic [RUNW-1:0] RUN_LIM = RUNW'(MAX_PULSE);
  localparam logic [RUNW-1:0] RUN_ONE = RUNW'(1);
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(LOCK_PERIODS);
  localparam logic [CNTW-1:0] CNT_ONE = CNTW'(1);

  logic            filt_node;   // NAND of the two active-low pulses
  logic            over;
  logic [RUNW-1:0] run_q, run_d;
  logic [CNTW-1:0] good_q, good_d;
  logic            lock_q, lock_d;

  always_comb begin
    filt_node = ~(up_n & dn_n);
    over      = filt_node && (run_q >= RUN_LIM);

    // Active-run length, saturating one past the limit
    if (!filt_node)          run_d = '0;
    else if (run_q > RUN_LIM) run_d = run_q;
    else                     run_d = run_q + RUN_ONE;

    good_d = good_q;
    if (over) begin
      good_d = '0;
    end else if (cmp_done && (good_q != CNT_TOP)) begin
      good_d = good_q + CNT_ONE;
    end
    lock_d = (good_d == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int unsigned RW           = 6,
  parameter int unsigned MAX_PULSE    = 4,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] div_ratio,
  input  logic          ref_in,
  input  logic          fb_in,
  output logic          ref_div,
  output logic          up_n,
  output logic          dn_n,
  output logic          lock
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       cmp_done;

  // Asynchronous assertion, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pfdl_ref_divider #(.RW(RW)) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ratio     (div_ratio),
    .ref_in    (ref_in),
    .div_pulse (ref_div)
  );

  pfdl_pfd_core u_pfd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ref_ev   (ref_div),
    .fb_in    (fb_in),
    .up_n     (up_n),
    .dn_n     (dn_n),
    .cmp_done (cmp_done)
  );

  pfdl_lock_filter #(
    .MAX_PULSE    (MAX_PULSE),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .up_n     (up_n),
    .dn_n     (dn_n),
    .cmp_done (cmp_done),
    .lock     (lock)
  );

endmodule

// File: rtl/pfd_lock_top_chk.sv
module pfd_lock_top_chk #(
  parameter int unsigned RW        = 6,
  parameter int unsigned MAX_PULSE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] div_ratio,
  input logic          ref_in,
  input logic          ref_div,
  input logic          up_n,
  input logic          dn_n,
  input logic          lock
);

  localparam int unsigned CRW = $clog2(MAX_PULSE + 2) + 1;
  localparam logic [CRW-1:0] CR_LIM = CRW'(MAX_PULSE);

  logic           chk_ref_q;
  logic [CRW-1:0] chk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ref_q <= 1'b0;
      chk_run   <= '0;
    end else begin
      chk_ref_q <= ref_in;
      if (!up_n || !dn_n) begin
        if (chk_run <= CR_LIM) chk_run <= chk_run + CRW'(1);
      end else begin
        chk_run <= '0;
      end
    end
  end

  assert_single_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div |=> !ref_div);

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ratio == '0 && ref_in && !chk_ref_q) |=> ref_div);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_n && !dn_n));

  assert_long_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_run > CR_LIM) |-> !lock);

endmodule

bind pfd_lock_top pfd_lock_top_chk #(.RW(RW), .MAX_PULSE(MAX_PULSE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .div_ratio (div_ratio),
  .ref_in    (ref_in),
  .ref_div   (ref_div),
  .up_n      (up_n),
  .dn_n      (dn_n),
  .lock      (lock)
);

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;

  localparam int MAXP = 4;
  localparam int NPER = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] div_ratio;
  logic       ref_in, fb_in;
  logic       ref_div, up_n, dn_n, lock;

  int total = 0;
  int bad   = 0;
  int up_lo, dn_lo, div_cnt, both_lo;
  int streak = 0;

  always #5 clk = ~clk;

  pfd_lock_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_ratio (div_ratio),
    .ref_in    (ref_in),
    .fb_in     (fb_in),
    .ref_div   (ref_div),
    .up_n      (up_n),
    .dn_n      (dn_n),
    .lock      (lock)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!up_n) up_lo++;
    if (!dn_n) dn_lo++;
    if (ref_div) div_cnt++;
    if (!up_n && !dn_n) both_lo++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic int exp_up(input int d);
    return (d > 0) ? d : 0;
  endfunction

  function automatic int exp_dn(input int d);
    return (d < 0) ? -d : 0;
  endfunction

  function automatic int iabs(input int d);
    return (d < 0) ? -d : d;
  endfunction

  // One comparison period: r non-completing reference edges, then the
  // completing edge with the feedback edge d cycles later (d<0: earlier).
  task automatic period(input int r, input int d, input int fh);
    int rc, fc, last;
    string tag;
    div_ratio = 6'(r);
    up_lo = 0; dn_lo = 0; div_cnt = 0; both_lo = 0;
    for (int i = 0; i < r; i++) begin
      ref_in = 1'b1; tick(1);
      ref_in = 1'b0; tick(3);
    end
    rc   = (d >= 0) ? 0 : -d;
    fc   = (d >= 0) ? d : 0;
    last = ((rc > fc) ? rc : fc + fh);
    for (int c = 0; c <= last; c++) begin
      ref_in = (c == rc);
      fb_in  = (c >= fc) && (c < fc + fh);
      tick(1);
    end
    ref_in = 1'b0; fb_in = 1'b0;
    tick(8);
    chk((r == 0) ? "R2 passthrough count" : "R1 divide count", div_cnt, 1);
    if (d > 0)       tag = (fh > 1) ? "R3/R6 up width" : "R3 up width";
    else if (d == 0) tag = "R5 aligned up";
    else             tag = "R4 up stays high";
    chk(tag, up_lo, exp_up(d));
    if (d < 0)       tag = (fh > 1) ? "R4/R6 down width" : "R4 down width";
    else if (d == 0) tag = "R5 aligned down";
    else             tag = (fh > 1) ? "R6 held feedback down" : "R3 down stays high";
    chk(tag, dn_lo, exp_dn(d));
    chk("R7 never both low", both_lo, 0);
    if (iabs(d) <= MAXP) begin
      if (streak < NPER) streak++;
    end else begin
      streak = 0;
    end
    chk((streak >= NPER) ? "R8 lock asserted" : "R8/R9 lock clear",
        int'(lock), (streak >= NPER) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; div_ratio = '0;
    void'($urandom(32'h1d2c_3b4a));
    tick(5);
    chk("R10 reset up_n", int'(up_n), 1);
    chk("R10 reset dn_n", int'(dn_n), 1);
    chk("R10 reset lock", int'(lock), 0);
    chk("R10 reset ref_div", int'(ref_div), 0);
    rst_n = 1'b1;
    tick(4);

    // Directed corners
    period(0, 0, 1);
    period(0, 3, 1);
    period(0, -3, 1);
    period(5, 2, 4);
    period(63, -1, 1);
    period(2, -5, 3);

    // Randomized phase offsets and ratios
    for (int k = 0; k < 60; k++) begin
      int r, d, fh;
      r  = int'($urandom_range(0, 6));
      d  = int'($urandom_range(0, 12)) - 6;
      fh = ($urandom_range(0, 3) == 0) ? 3 : 1;
      period(r, d, fh);
    end

    // Lock build-up at the limit, then the first over-long pulse
    period(1, MAXP + 2, 1);
    for (int k = 0; k < NPER; k++) period(k % 3, (k % 2 == 0) ? MAXP : -MAXP, 1);
    period(0, MAXP, 1);
    period(0, -(MAXP + 1), 1);
    period(0, 0, 1);

    // Asynchronous reset while an up pulse is pending
    div_ratio = '0;
    ref_in = 1'b1; tick(1); ref_in = 1'b0; tick(3);
    chk("R3 up pending before reset", int'(up_n), 0);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset clears up_n", int'(up_n), 1);
    chk("R10 async reset clears lock", int'(lock), 0);
    tick(2);
    rst_n = 1'b1;
    streak = 0;
    tick(4);
    period(1, 2, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule